// File: doc/BRIEF.md
# Floppy Controller Power-Down and Wake Logic

This block controls power for a floppy-disk-controller style peripheral that sits on a simple host register bus. A host write that sets the power-down bit of the rate-select register moves the block into a low-power state on the next clock edge. While it is in that state, the clock-enable outputs for the internal clock domains are all held low. These domains are the data separator, the embedded sequencer and the write precompensation unit.

There are two ways to leave the low-power state. The first is a host read or write of the data register or the status register. This wake keeps every internal register value, and the access itself completes normally. The second is a software reset, issued through either the drive-control register or the rate-select register. This wake sends a one-cycle reset request to the rest of the controller and returns every register to its default value.

A status output shows the present power state. The power-down bit in the rate-select register reads back 0 after any wake.

Top module: `fdc_lpm_ctrl`

Register map, by `addr_i`:

| addr_i | Name | Access | Fields |
|---|---|---|---|
| 0 | drive-control | read/write | bit 2 is active-low reset |
| 1 | rate-select | read/write | bit 7 is software reset (reads 0), bit 6 is power-down, bits 5:0 are the rate field |
| 2 | status | read | held copy of `stat_i`; writes have no effect on the data |
| 3 | data | read/write | data register |

## Requirements
- R1: A write to address 1 with bit 6 = 1 and bit 7 = 0 sets `pwr_down_o` to 1 in the cycle right after the write edge. No other condition is needed.
- R2: While `pwr_down_o` is 1, every bit of `clk_en_o` is 0. While `pwr_down_o` is 0, every bit of `clk_en_o` is 1.
- R3: A software reset clears `pwr_down_o` and raises `sw_rst_o` in the cycle after the write edge. A software reset is either a write to address 0 with bit 2 = 0, or a write to address 1 with bit 7 = 1. After it, drive-control reads 0x04, rate-select reads 0x02 and data reads 0x00. A software reset takes priority over a power-down bit written at the same time.
- R4: While `pwr_down_o` is 1, a read or a write of address 2 or address 3 clears `pwr_down_o` in the cycle after the access edge.
- R5: A wake caused by an access keeps the drive-control, rate field and data register values. A data write that causes a wake stores its data. The status copy does not follow `stat_i` while the block is powered down, so a read that causes a wake returns the value that was held.
- R6: `sw_rst_o` stays low after a wake caused by an access, and it is never high for two cycles in a row.
- R7: Reading address 1 returns bit 6 equal to `pwr_down_o` and bit 7 equal to 0. After any wake, bit 6 reads 0.
- R8: While powered down, reads of addresses 0 and 1 do not wake the block. Writes to those addresses that are not software resets do not wake it either. A rate-select write with bit 6 = 0 updates the rate field, and the block stays powered down.
- R9: `rdata_o` is 0 when `rd_i` is low. When `rd_i` is high, `rdata_o` shows the register at `addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| stat_i | input | 8 | Live status from the controller core |
| clk_en_o | output | 3 | Clock enables: data separator, sequencer, precompensation |
| pwr_down_o | output | 1 | High while in the low-power state |
| sw_rst_o | output | 1 | One-cycle reset request to the core |

## Verification
A wrong power state shows up one cycle after the triggering edge, both on `pwr_down_o` and on the whole `clk_en_o` vector. Errors in the stored values only appear when that register is read back. For that reason the bench reads the drive-control, rate and data registers right after every wake and every reset. A status copy that keeps following `stat_i` during power-down shows up on the read that causes the wake, because `stat_i` is changed while the block is powered down. A missing or stretched reset pulse shows up on `sw_rst_o` in the first or second cycle after the write.

// File: rtl/fdc_lpm_pkg.sv
package fdc_lpm_pkg;
  localparam int unsigned AW = 2;
  localparam int unsigned DW = 8;
  localparam int unsigned RATE_W = 6;

  localparam logic [AW-1:0] A_CTL  = 2'd0;
  localparam logic [AW-1:0] A_RATE = 2'd1;
  localparam logic [AW-1:0] A_STAT = 2'd2;
  localparam logic [AW-1:0] A_DATA = 2'd3;

  localparam int unsigned CTL_RSTN_BIT  = 2;
  localparam int unsigned RATE_PD_BIT   = 6;
  localparam int unsigned RATE_SRST_BIT = 7;

  localparam logic [DW-1:0]     CTL_DEF  = 8'h04;
  localparam logic [RATE_W-1:0] RATE_DEF = 6'h02;
  localparam logic [DW-1:0]     DATA_DEF = 8'h00;

  typedef enum logic {
    PM_RUN  = 1'b0,
    PM_DOWN = 1'b1
  } pm_state_e;
endpackage

// File: rtl/fdc_lpm_decode.sv
module fdc_lpm_decode
  import fdc_lpm_pkg::*;
(
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          rst_req_o,
  output logic          pd_req_o,
  output logic          wake_acc_o,
  output logic          ctl_we_o,
  output logic          rate_we_o,
  output logic          data_we_o
);
  logic wr_ctl, wr_rate;

  always_comb begin
    wr_ctl     = wr_i && (addr_i == A_CTL);
    wr_rate    = wr_i && (addr_i == A_RATE);
    rst_req_o  = (wr_ctl && !wdata_i[CTL_RSTN_BIT]) ||
                 (wr_rate && wdata_i[RATE_SRST_BIT]);
    // reset wins over a power-down bit in the same write
    pd_req_o   = wr_rate && wdata_i[RATE_PD_BIT] && !wdata_i[RATE_SRST_BIT];
    wake_acc_o = (wr_i || rd_i) && ((addr_i == A_STAT) || (addr_i == A_DATA));
    ctl_we_o   = wr_ctl && !rst_req_o;
    rate_we_o  = wr_rate && !rst_req_o;
    data_we_o  = wr_i && (addr_i == A_DATA);
  end
endmodule

// File: rtl/fdc_lpm_fsm.sv
module fdc_lpm_fsm
  import fdc_lpm_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rst_req_i,
  input  logic      pd_req_i,
  input  logic      wake_acc_i,
  output pm_state_e state_o,
  output logic      sw_rst_o
);
  pm_state_e state_q, state_d;
  logic      sw_rst_q;

  always_comb begin
    state_d = state_q;
    if (rst_req_i) begin
      state_d = PM_RUN;
    end else begin
      unique case (state_q)
        PM_RUN:  if (pd_req_i)   state_d = PM_DOWN;
        PM_DOWN: if (wake_acc_i) state_d = PM_RUN;
        default: state_d = PM_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= PM_RUN;
      sw_rst_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      sw_rst_q <= rst_req_i;
    end
  end

  assign state_o  = state_q;
  assign sw_rst_o = sw_rst_q;

  AST_PD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_req_i |=> state_q == PM_DOWN); // R1
  AST_SRST_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (state_q == PM_RUN) && sw_rst_q); // R3
  AST_ACC_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DOWN) && wake_acc_i |=> state_q == PM_RUN); // R4
  AST_NO_PULSE_ON_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DOWN) && wake_acc_i && !rst_req_i |=> !sw_rst_q); // R6
  AST_DOWN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PM_DOWN) && !wake_acc_i && !rst_req_i |=> state_q == PM_DOWN); // R8
endmodule

// File: rtl/fdc_lpm_regs.sv
module fdc_lpm_regs
  import fdc_lpm_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rst_req_i,
  input  logic          ctl_we_i,
  input  logic          rate_we_i,
  input  logic          data_we_i,
  input  logic          down_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] stat_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0]     ctl_q, data_q, stat_q;
  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= CTL_DEF;
      rate_q <= RATE_DEF;
      data_q <= DATA_DEF;
      stat_q <= '0;
    end else if (rst_req_i) begin
      ctl_q  <= CTL_DEF;
      rate_q <= RATE_DEF;
      data_q <= DATA_DEF;
      stat_q <= '0;
    end else begin
      if (ctl_we_i)  ctl_q  <= wdata_i;
      if (rate_we_i) rate_q <= wdata_i[RATE_W-1:0];
      if (data_we_i) data_q <= wdata_i;
      // status copy frozen while the core clocks are off
      if (!down_i)   stat_q <= stat_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        A_CTL:   rdata_o = ctl_q;
        A_RATE:  rdata_o = {1'b0, down_i, rate_q};
        A_STAT:  rdata_o = stat_q;
        default: rdata_o = data_q;
      endcase
    end
  end

  AST_STAT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_i && !rst_req_i |=> $stable(stat_q)); // R5
  AST_DATA_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    down_i && !data_we_i && !rst_req_i |=> $stable(data_q)); // R5
  AST_SRST_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> (ctl_q == CTL_DEF) && (rate_q == RATE_DEF) && (data_q == DATA_DEF)); // R3
endmodule

// File: rtl/fdc_lpm_clk_en.sv
module fdc_lpm_clk_en #(
  parameter int unsigned N_DOMAINS = 3
) (
  input  logic                 down_i,
  output logic [N_DOMAINS-1:0] clk_en_o
);
  for (genvar g = 0; g < N_DOMAINS; g++) begin : g_dom
    assign clk_en_o[g] = !down_i;
  end
endmodule

// File: rtl/fdc_lpm_ctrl.sv
module fdc_lpm_ctrl
  import fdc_lpm_pkg::*;
#(
  parameter int unsigned N_DOMAINS = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [DW-1:0]        stat_i,
  output logic [N_DOMAINS-1:0] clk_en_o,
  output logic                 pwr_down_o,
  output logic                 sw_rst_o
);
  logic      rst_req, pd_req, wake_acc, ctl_we, rate_we, data_we, down;
  pm_state_e state;

  fdc_lpm_decode u_dec (
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rst_req_o  (rst_req),
    .pd_req_o   (pd_req),
    .wake_acc_o (wake_acc),
    .ctl_we_o   (ctl_we),
    .rate_we_o  (rate_we),
    .data_we_o  (data_we)
  );

  fdc_lpm_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_req_i  (rst_req),
    .pd_req_i   (pd_req),
    .wake_acc_i (wake_acc),
    .state_o    (state),
    .sw_rst_o   (sw_rst_o)
  );

  assign down       = (state == PM_DOWN);
  assign pwr_down_o = down;

  fdc_lpm_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rst_req_i (rst_req),
    .ctl_we_i  (ctl_we),
    .rate_we_i (rate_we),
    .data_we_i (data_we),
    .down_i    (down),
    .rd_i      (rd_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .stat_i    (stat_i),
    .rdata_o   (rdata_o)
  );

  fdc_lpm_clk_en #(.N_DOMAINS(N_DOMAINS)) u_cen (
    .down_i   (down),
    .clk_en_o (clk_en_o)
  );

  AST_GATED_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_o |-> clk_en_o == '0); // R2
  AST_ENABLED_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_down_o |-> &clk_en_o); // R2
  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0); // R9
  AST_PULSE_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_o && !(wr_i && (addr_i == A_CTL) && !wdata_i[CTL_RSTN_BIT])
             && !(wr_i && (addr_i == A_RATE) && wdata_i[RATE_SRST_BIT]) |=> !sw_rst_o); // R6
endmodule

// File: tb/tb_fdc_lpm_ctrl.sv
module tb_fdc_lpm_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, stat = '0;
  logic [7:0] rdata;
  logic [2:0] clk_en;
  logic       pwr_down, sw_rst;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fdc_lpm_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .stat_i(stat), .clk_en_o(clk_en),
    .pwr_down_o(pwr_down), .sw_rst_o(sw_rst)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic chk_state(input string tag, input logic exp_down);
    chk({tag, " pwr_down"}, {7'd0, pwr_down}, {7'd0, exp_down});
    chk("R2 clk_en", {5'd0, clk_en}, exp_down ? 8'h00 : 8'h07);
  endtask

  task automatic chk_defaults(input string tag);
    logic [7:0] v;
    bus_rd(2'd0, v); chk({tag, " ctl default"}, v, 8'h04);
    bus_rd(2'd1, v); chk({tag, " rate default"}, v, 8'h02);
    bus_rd(2'd3, v); chk({tag, " data default"}, v, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, ctl_m, data_m, held;
    logic [5:0] rate_m;
    stat = 8'h5A;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1 reset", 1'b0);
    chk("R6 reset sw_rst", {7'd0, sw_rst}, 8'h00);
    chk("R9 idle rdata", rdata, 8'h00);
    chk_defaults("R3 por");
    bus_rd(2'd2, v); chk("R9 status read", v, 8'h5A);
    ctl_m = 8'h04; rate_m = 6'h02; data_m = 8'h00;

    // sweep: every address x read/write while powered down
    for (int a = 0; a < 4; a++) begin
      for (int op = 0; op < 2; op++) begin
        logic exp_down;
        held = 8'h50 + 8'(a * 2 + op);
        stat = held;
        data_m = 8'h30 + 8'(a * 2 + op);
        bus_wr(2'd3, data_m);
        bus_wr(2'd1, 8'h40 | 8'(a));
        rate_m = 6'(a);
        chk_state("R1 enter", 1'b1);
        stat = 8'hA0 + 8'(a * 2 + op);
        @(negedge clk);
        bus_rd(2'd1, v); chk("R7 rate pd readback", v, 8'h40 | 8'(a));
        chk_state("R8 rate read no wake", 1'b1);
        if (op == 0) begin
          case (a)
            0: begin bus_wr(2'd0, 8'h0C); ctl_m = 8'h0C; end
            1: begin bus_wr(2'd1, 8'h01); rate_m = 6'h01; end
            2: bus_wr(2'd2, 8'hFF);
            default: begin bus_wr(2'd3, 8'h77); data_m = 8'h77; end
          endcase
        end else begin
          bus_rd(2'(a), v);
          case (a)
            0: chk("R8 ctl read down", v, ctl_m);
            1: chk("R7 rate read down", v, 8'h40 | {2'b00, rate_m});
            2: chk("R5 waking status read", v, held);
            default: chk("R5 waking data read", v, data_m);
          endcase
        end
        exp_down = (a < 2);
        chk_state(exp_down ? "R8 no wake" : "R4 access wake", exp_down);
        chk("R6 no pulse", {7'd0, sw_rst}, 8'h00);
        if (exp_down) begin
          bus_rd(2'd2, v); chk("R5 held status", v, held);
          chk_state("R4 status wake", 1'b0);
        end
        bus_rd(2'd0, v); chk("R5 ctl kept", v, ctl_m);
        bus_rd(2'd1, v); chk("R7 pd cleared", v, {2'b00, rate_m});
        bus_rd(2'd3, v); chk("R5 data kept", v, data_m);
        bus_rd(2'd2, v); chk("R5 status follows", v, stat);
      end
    end

    // software reset via ctl while down
    bus_wr(2'd3, 8'h99);
    bus_wr(2'd1, 8'h41);
    chk_state("R1 enter", 1'b1);
    bus_wr(2'd0, 8'h00);
    chk_state("R3 ctl reset exit", 1'b0);
    chk("R3 pulse", {7'd0, sw_rst}, 8'h01);
    @(negedge clk);
    chk("R6 pulse one cycle", {7'd0, sw_rst}, 8'h00);
    chk_defaults("R3 ctl");

    // software reset via rate bit7 while down
    bus_wr(2'd3, 8'h66);
    bus_wr(2'd1, 8'h43);
    chk_state("R1 enter", 1'b1);
    bus_wr(2'd1, 8'h80);
    chk_state("R3 rate reset exit", 1'b0);
    chk("R3 pulse", {7'd0, sw_rst}, 8'h01);
    @(negedge clk);
    chk("R6 pulse one cycle", {7'd0, sw_rst}, 8'h00);
    chk_defaults("R3 rate");

    // reset and power-down in one write: reset wins
    bus_wr(2'd3, 8'h55);
    bus_wr(2'd1, 8'hC1);
    chk_state("R3 reset beats pd", 1'b0);
    chk("R3 pulse", {7'd0, sw_rst}, 8'h01);
    @(negedge clk);
    chk("R6 pulse one cycle", {7'd0, sw_rst}, 8'h00);
    chk_defaults("R3 combo");

    // reset while running
    bus_wr(2'd0, 8'h08);
    chk_state("R3 run reset", 1'b0);
    chk("R3 pulse", {7'd0, sw_rst}, 8'h01);
    chk_defaults("R3 run");
    chk("R9 idle rdata", rdata, 8'h00);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule